// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Control

This block steers the two ALU operand multiplexers of a five-stage in-order pipeline (Fetch, Decode, Compute, Memory, Writeback). It keeps its own copy of the register identifiers that travel through the Decode/Compute, Compute/Memory and Memory/Writeback buffers. Each cycle it compares the two source identifiers of the instruction in Compute against the destinations of the two older instructions ahead of it. For each operand it then picks the register-file value, the ALU result waiting in the Compute/Memory buffer, or the value waiting in the Memory/Writeback buffer.

A load only has its data after the Memory stage, so an instruction that uses the loaded value right behind the load cannot be served by the Compute/Memory path. The block finds this case while the consumer is still in Decode. It raises a stall request for exactly one cycle and places one bubble into Compute. The consumer then picks up the loaded value from the Memory/Writeback path. The pipeline around the block must hold Fetch/Decode while the stall request is high and present the same instruction again.

Top module: `fwd_hazard_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it with no valid instruction issued, `selA` and `selB` read 00 and `stall` reads 0.
- R2: An operand selects code 01 (Compute/Memory buffer) when the instruction in Memory writes a nonzero register equal to that operand's source in Compute.
- R3: An operand selects code 10 (Memory/Writeback buffer) when the instruction in Writeback writes a nonzero register equal to that operand's source, and R2 does not apply.
- R4: When the producers in Memory and Writeback both match one source, that operand selects 01, so the younger result wins.
- R5: A producer that does not write a register, or whose destination is register 0, never causes a forward. With no qualifying match the code is 00 (register file).
- R6: `stall` is 1 in the cycle when a valid instruction in Decode reads a nonzero register that a load now in Compute writes. At the next edge a bubble enters Compute and the load moves on to Memory.
- R7: `stall` stays 0 when the matching producer in Compute is not a load, and when a load sits in Memory or deeper.
- R8: Operands A and B are resolved independently and may receive different codes in the same cycle.
- R9: Invalid slots, whether bubbles or an empty Decode (`decValid`=0), neither forward nor stall. An invalid instruction in Compute gets code 00 on both operands.
- R10: A stall lasts one cycle. When the held consumer is presented again it is not stalled, and it then receives the load result through code 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| decValid | input | 1 | Decode slot holds a real instruction |
| decSrcA | input | 5 | Source register of operand A in Decode |
| decSrcB | input | 5 | Source register of operand B in Decode |
| decDst | input | 5 | Destination register of the Decode instruction |
| decWrites | input | 1 | Decode instruction writes its destination |
| decLoad | input | 1 | Decode instruction is a load |
| selA | output | 2 | Operand A select: 00 register file, 01 Compute/Memory, 10 Memory/Writeback |
| selB | output | 2 | Operand B select, same encoding |
| stall | output | 1 | Hold Fetch/Decode this cycle; a bubble enters Compute |

## Verification
A corrupted identifier or a lost valid bit in the internal buffers shows up as a wrong select code, either one or two cycles after the instruction leaves Decode, depending on which buffer is wrong. A wrong load flag in Compute shows up in the same cycle as a missing or spurious stall. A dropped bubble shows up one cycle later as a repeated stall, or as the held consumer taking the Compute/Memory path for a load. The bench keeps an independent model of the three buffers. It checks every output against that model in every cycle of a long stream of instructions confined to four registers, so that matches, zero-register cases and double matches occur often.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  parameter int unsigned REG_ID_W = 5;
  parameter int unsigned NUM_OPS  = 2;

  typedef logic [REG_ID_W-1:0] regId_t;
  localparam regId_t ZERO_ID = '0;

  typedef enum logic [1:0] {
    SEL_RF = 2'b00,
    SEL_CM = 2'b01,
    SEL_MW = 2'b10
  } fwdSel_e;

  typedef struct packed {
    logic                      valid;
    logic                      writes;
    logic                      isLoad;
    regId_t                    dst;
    logic [NUM_OPS-1:0][REG_ID_W-1:0] src;
  } stageInfo_t;

  typedef struct packed {
    logic injectBubble;
    logic holdFront;
  } ctlStrobe_t;

  function automatic logic producesReg(stageInfo_t s);
    return s.valid && s.writes && (s.dst != ZERO_ID);
  endfunction
endpackage

// File: rtl/fwd_id_pipe.sv
module fwd_id_pipe
  import fwd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  stageInfo_t decInfo,
  input  ctlStrobe_t strobe,
  output stageInfo_t exInfo,
  output stageInfo_t memInfo,
  output stageInfo_t wbInfo
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exInfo  <= '0;
      memInfo <= '0;
      wbInfo  <= '0;
    end else begin
      exInfo  <= strobe.injectBubble ? '0 : decInfo;
      memInfo <= exInfo;
      wbInfo  <= memInfo;
    end
  end
endmodule

// File: rtl/fwd_ctl.sv
module fwd_ctl
  import fwd_pkg::*;
(
  input  stageInfo_t             decInfo,
  input  stageInfo_t             exInfo,
  input  stageInfo_t             memInfo,
  input  stageInfo_t             wbInfo,
  output logic [NUM_OPS-1:0][1:0] selVec,
  output ctlStrobe_t             strobe
);
  logic [NUM_OPS-1:0] loadUseHit;
  logic               cmLive;
  logic               mwLive;
  logic               ldLive;

  assign cmLive = producesReg(memInfo);
  assign mwLive = producesReg(wbInfo);
  assign ldLive = producesReg(exInfo) && exInfo.isLoad;

  for (genvar op = 0; op < NUM_OPS; op++) begin : gOperand
    logic cmHit;
    logic mwHit;
    fwdSel_e pick;

    assign cmHit = cmLive && (memInfo.dst == exInfo.src[op]);
    assign mwHit = mwLive && (wbInfo.dst == exInfo.src[op]);

    always_comb begin
      pick = SEL_RF;
      if (exInfo.valid) begin
        if (cmHit)      pick = SEL_CM;
        else if (mwHit) pick = SEL_MW;
      end
    end

    assign selVec[op]     = pick;
    assign loadUseHit[op] = decInfo.valid && ldLive && (exInfo.dst == decInfo.src[op]);
  end

  assign strobe.injectBubble = |loadUseHit;
  assign strobe.holdFront    = |loadUseHit;
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import fwd_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                decValid,
  input  logic [REG_ID_W-1:0] decSrcA,
  input  logic [REG_ID_W-1:0] decSrcB,
  input  logic [REG_ID_W-1:0] decDst,
  input  logic                decWrites,
  input  logic                decLoad,
  output logic [1:0]          selA,
  output logic [1:0]          selB,
  output logic                stall
);
  stageInfo_t              decInfo;
  stageInfo_t              exInfo;
  stageInfo_t              memInfo;
  stageInfo_t              wbInfo;
  ctlStrobe_t              strobe;
  logic [NUM_OPS-1:0][1:0] selVec;

  always_comb begin
    decInfo        = '0;
    decInfo.valid  = decValid;
    decInfo.writes = decWrites;
    decInfo.isLoad = decLoad;
    decInfo.dst    = decDst;
    decInfo.src[0] = decSrcA;
    decInfo.src[1] = decSrcB;
  end

  fwd_id_pipe uPipe (
    .clk    (clk),
    .rstN   (rstN),
    .decInfo(decInfo),
    .strobe (strobe),
    .exInfo (exInfo),
    .memInfo(memInfo),
    .wbInfo (wbInfo)
  );

  fwd_ctl uCtl (
    .decInfo(decInfo),
    .exInfo (exInfo),
    .memInfo(memInfo),
    .wbInfo (wbInfo),
    .selVec (selVec),
    .strobe (strobe)
  );

  assign selA  = selVec[0];
  assign selB  = selVec[1];
  assign stall = strobe.holdFront;
endmodule

// File: rtl/fwd_hazard_checker.sv
module fwd_hazard_checker
  import fwd_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       decValid,
  input logic [1:0] selA,
  input logic [1:0] selB,
  input logic       stall,
  input stageInfo_t exInfo,
  input stageInfo_t memInfo,
  input stageInfo_t wbInfo
);
  a_r1_legal_codes: assert property (@(posedge clk) disable iff (!rstN)
    (selA != 2'b11) && (selB != 2'b11));

  a_r2_cm_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    (selA == 2'b01) |-> (memInfo.valid && memInfo.writes &&
                         memInfo.dst != '0 && memInfo.dst == exInfo.src[0]));

  a_r3_mw_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    (selB == 2'b10) |-> (wbInfo.valid && wbInfo.writes &&
                         wbInfo.dst != '0 && wbInfo.dst == exInfo.src[1]));

  a_r6_bubble_after_stall: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !exInfo.valid);

  a_r6_no_load_on_cm_path: assert property (@(posedge clk) disable iff (!rstN)
    (exInfo.valid && memInfo.valid && memInfo.writes && memInfo.isLoad && memInfo.dst != '0)
      |-> (memInfo.dst != exInfo.src[0] && memInfo.dst != exInfo.src[1]));

  a_r9_idle_compute_rf: assert property (@(posedge clk) disable iff (!rstN)
    !exInfo.valid |-> (selA == 2'b00 && selB == 2'b00));

  a_r9_empty_decode_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> !stall);

  a_r10_single_stall: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall);
endmodule

bind fwd_hazard_unit fwd_hazard_checker uChk (
  .clk     (clk),
  .rstN    (rstN),
  .decValid(decValid),
  .selA    (selA),
  .selB    (selB),
  .stall   (stall),
  .exInfo  (exInfo),
  .memInfo (memInfo),
  .wbInfo  (wbInfo)
);

// File: tb/tb_fwd_hazard_unit.sv
`timescale 1ns/1ps
module tb_fwd_hazard_unit;
  import fwd_pkg::*;

  logic                clk = 1'b0;
  logic                rstN;
  logic                decValid;
  logic [REG_ID_W-1:0] decSrcA, decSrcB, decDst;
  logic                decWrites, decLoad;
  logic [1:0]          selA, selB;
  logic                stall;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  fwd_hazard_unit dut (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decSrcA(decSrcA), .decSrcB(decSrcB),
    .decDst(decDst), .decWrites(decWrites), .decLoad(decLoad),
    .selA(selA), .selB(selB), .stall(stall)
  );

  stageInfo_t mEx, mMem, mWb, pending;
  bit prevStall;

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit writesNz(stageInfo_t s);
    return s.valid && s.writes && s.dst != 0;
  endfunction

  function automatic logic [1:0] refSel(int op);
    if (!mEx.valid) return 2'b00;
    if (writesNz(mMem) && mMem.dst == mEx.src[op]) return 2'b01;
    if (writesNz(mWb) && mWb.dst == mEx.src[op]) return 2'b10;
    return 2'b00;
  endfunction

  function automatic string selTag(int op, logic [1:0] e, logic [1:0] other);
    bit cm = writesNz(mMem) && mMem.dst == mEx.src[op];
    bit mw = writesNz(mWb) && mWb.dst == mEx.src[op];
    if (op == 1 && e != other) return "R8";
    if (!mEx.valid) return "R9";
    if (cm && mw) return "R4";
    if (cm) return "R2";
    if (mw) return "R3";
    return "R5";
  endfunction

  function automatic stageInfo_t newInstr();
    stageInfo_t s;
    s        = '0;
    s.valid  = ($urandom_range(0, 9) != 0);
    s.writes = ($urandom_range(0, 3) != 0);
    s.isLoad = s.writes && ($urandom_range(0, 9) < 4);
    s.dst    = REG_ID_W'($urandom_range(0, 3));
    s.src[0] = REG_ID_W'($urandom_range(0, 3));
    s.src[1] = REG_ID_W'($urandom_range(0, 3));
    return s;
  endfunction

  task automatic drive(stageInfo_t s);
    decValid  = s.valid;
    decWrites = s.writes;
    decLoad   = s.isLoad;
    decDst    = s.dst;
    decSrcA   = s.src[0];
    decSrcB   = s.src[1];
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    drive('0);
    mEx = '0; mMem = '0; mWb = '0; prevStall = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset selA", selA, 2'b00);
    chk("R1 reset selB", selB, 2'b00);
    chk("R1 reset stall", {1'b0, stall}, 2'b00);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 post-reset selA", selA, 2'b00);
    chk("R1 post-reset stall", {1'b0, stall}, 2'b00);

    pending = newInstr();
    for (int cyc = 0; cyc < 6000; cyc++) begin
      bit expStall;
      logic [1:0] eA, eB;
      string sTag;
      @(negedge clk);
      drive(pending);
      #1;
      expStall = pending.valid && writesNz(mEx) && mEx.isLoad &&
                 (mEx.dst == pending.src[0] || mEx.dst == pending.src[1]);
      if (!pending.valid) sTag = "R9 stall";
      else if (prevStall) sTag = "R10 stall";
      else if (expStall) sTag = "R6 stall";
      else sTag = "R7 stall";
      chk(sTag, {1'b0, stall}, {1'b0, expStall});
      eA = refSel(0);
      eB = refSel(1);
      chk({selTag(0, eA, eB), " selA"}, selA, eA);
      chk({selTag(1, eB, eA), " selB"}, selB, eB);
      @(posedge clk);
      mWb  = mMem;
      mMem = mEx;
      mEx  = expStall ? stageInfo_t'('0) : pending;
      prevStall = expStall;
      if (!expStall) pending = newInstr();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule